// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Cell

This block is the scan logic for a single bidirectional digital pin that has a pull-up. It sits between the port logic and the pad. The port logic supplies an output enable, output data and a pull-up enable. The scan chain can observe the pin through the block and can also drive it. All scan state is clocked by the test clock `clk`, and the strobes are synchronous to that clock.

There are three shift stages, placed in this order from `scan_in`:

1. a plain cell for the pull-up enable;
2. a stage for output control;
3. a stage that serves both output data and input data.

The third stage does double duty. On a capture it takes the raw pad level, with no synchronizer in the path. On an update its content becomes the driven data value. So output control, output data and input data together need only two stages.

Each stage has an update latch behind it. When `extest` is low, the port logic drives the pad and scan activity cannot disturb the pin. This allows sampling and preloading while the system runs normally. When `extest` is high, the update latches drive the pad.

Top module: `bsc_pin_cell`

## Requirements
- R1: After a synchronous reset, all three shift stages and all three update latches are 0. As a result, `scan_out` is 0, and the pad outputs are 0 whenever `extest` is high before the first update.
- R2: On a clock edge with `capture_en` high, the stages load the following values, taken as they are at that edge:
  - the pull-up stage loads `port_pue`;
  - the control stage loads `port_oe`;
  - the data stage loads `pad_in`.
- R3: On a clock edge with `shift_en` high and `capture_en` low, the chain moves one position. `scan_in` enters the pull-up stage, the pull-up stage moves to the control stage, and the control stage moves to the data stage.
- R4: If `capture_en` and `shift_en` are both high, the capture takes effect and the shift is ignored.
- R5: On an edge with `update_en` high, each update latch copies its shift stage's value from before that edge. On every other edge the latches keep their values.
- R6: With `extest` low, `pad_oe`, `pad_do` and `pad_pue` follow `port_oe`, `port_do` and `port_pue` combinationally, whatever the latches hold.
- R7: With `extest` high, `pad_oe`, `pad_do` and `pad_pue` equal the control, data and pull-up latches respectively.
- R8: `scan_out` is the data stage. The stages keep their values on edges with neither `capture_en` nor `shift_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | 1 | Serial scan input |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| extest | input | 1 | Pad driven from update latches when high |
| port_oe | input | 1 | Output enable from port logic |
| port_do | input | 1 | Output data from port logic |
| port_pue | input | 1 | Pull-up enable from port logic |
| pad_in | input | 1 | Raw level seen at the pin |
| pad_oe | output | 1 | Output enable to the pad |
| pad_do | output | 1 | Output data to the pad |
| pad_pue | output | 1 | Pull-up enable to the pad |
| scan_out | output | 1 | Serial scan output |

## Verification
The assertions run on every cycle. They check that each stage either captures its source, shifts from its neighbour or holds. They check that each latch loads only on update and holds otherwise. They check that `scan_out` is clear right after reset, and that pad outputs stay steady under `extest` while no update occurs.

The bench's scenarios cover the behaviours that span many cycles or combine several inputs:
- the serial order of a full three-bit pattern;
- capture winning over a simultaneous shift;
- the pad following the port combinationally in sample mode;
- a preloaded pattern appearing on the pad once `extest` is raised.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int unsigned CHAIN_LEN = 3;

    typedef struct packed {
        logic pue;
        logic oe;
        logic dat;
    } pin_drive_t;

    function automatic pin_drive_t pick_drive(input logic ext_mode,
                                              input pin_drive_t from_scan,
                                              input pin_drive_t from_port);
        return ext_mode ? from_scan : from_port;
    endfunction

endpackage

// File: rtl/bsc_stage_cell.sv
module bsc_stage_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cap_src,
    input  logic ser_in,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    output logic stage_q,
    output logic latch_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= RST_VAL;
        end else if (capture_en) begin
            stage_q <= cap_src;
        end else if (shift_en) begin
            stage_q <= ser_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= RST_VAL;
        end else if (update_en) begin
            latch_q <= stage_q;
        end
    end

    // R2 capture loads source
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        capture_en |=> stage_q == $past(cap_src));
    // R3 / R4 shift only without capture
    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !capture_en) |=> stage_q == $past(ser_in));
    // R8 hold when idle
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !capture_en) |=> $stable(stage_q));
    // R5 latch load and hold
    p_update_r5: assert property (@(posedge clk) disable iff (rst)
        update_en |=> latch_q == $past(stage_q));
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !update_en |=> $stable(latch_q));

endmodule

// File: rtl/bsc_bidir_seg.sv
module bsc_bidir_seg (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    input  logic port_oe,
    input  logic pad_in,
    output logic ctl_latch,
    output logic dat_latch,
    output logic ser_out
);

    logic ctl_stage;

    bsc_stage_cell #(.RST_VAL(1'b0)) u_ctl (
        .clk(clk), .rst(rst), .cap_src(port_oe), .ser_in(ser_in),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .stage_q(ctl_stage), .latch_q(ctl_latch)
    );

    // data stage: captures the raw pin level, updates drive data
    bsc_stage_cell #(.RST_VAL(1'b0)) u_dat (
        .clk(clk), .rst(rst), .cap_src(pad_in), .ser_in(ctl_stage),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .stage_q(ser_out), .latch_q(dat_latch)
    );

endmodule

// File: rtl/bsc_pin_cell.sv
module bsc_pin_cell
    import bsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scan_in,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    input  logic extest,
    input  logic port_oe,
    input  logic port_do,
    input  logic port_pue,
    input  logic pad_in,
    output logic pad_oe,
    output logic pad_do,
    output logic pad_pue,
    output logic scan_out
);

    logic       pu_stage;
    pin_drive_t scan_drv;
    pin_drive_t port_drv;
    pin_drive_t pad_drv;

    bsc_stage_cell #(.RST_VAL(1'b0)) u_pu (
        .clk(clk), .rst(rst), .cap_src(port_pue), .ser_in(scan_in),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .stage_q(pu_stage), .latch_q(scan_drv.pue)
    );

    bsc_bidir_seg u_seg (
        .clk(clk), .rst(rst), .ser_in(pu_stage),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .port_oe(port_oe), .pad_in(pad_in),
        .ctl_latch(scan_drv.oe), .dat_latch(scan_drv.dat), .ser_out(scan_out)
    );

    always_comb begin
        port_drv = '{pue: port_pue, oe: port_oe, dat: port_do};
        pad_drv  = pick_drive(extest, scan_drv, port_drv);
        pad_oe   = pad_drv.oe;
        pad_do   = pad_drv.dat;
        pad_pue  = pad_drv.pue;
    end

    // R1 chain output clear right after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> scan_out == 1'b0);
    // R7 pad steady under extest while no update occurs
    p_ext_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (extest && !update_en) |=>
            (!extest || ($stable(pad_oe) && $stable(pad_do) && $stable(pad_pue))));

endmodule

// File: tb/bsc_pin_cell_bench.sv
module bsc_pin_cell_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_in = 0, capture_en = 0, shift_en = 0, update_en = 0, extest = 0;
    logic port_oe = 0, port_do = 0, port_pue = 0, pad_in = 0;
    logic pad_oe, pad_do, pad_pue, scan_out;

    int checks = 0;
    int errors = 0;

    // reference state: index 0 pull-up, 1 control, 2 data
    logic [2:0] m_stage = '0;
    logic [2:0] m_latch = '0;

    always #5 clk = ~clk;

    bsc_pin_cell u_bsc_pin_cell (
        .clk(clk), .rst(rst), .scan_in(scan_in), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .extest(extest),
        .port_oe(port_oe), .port_do(port_do), .port_pue(port_pue),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do),
        .pad_pue(pad_pue), .scan_out(scan_out)
    );

    function automatic logic [2:0] exp_pad(input logic ext, input logic [2:0] lat,
                                           input logic oe, input logic dq, input logic pu);
        // returns {oe, do, pue}
        return ext ? {lat[1], lat[2], lat[0]} : {oe, dq, pu};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [2:0] e;
        e = exp_pad(extest, m_latch, port_oe, port_do, port_pue);
        chk({req, " scan_out (R8)"}, scan_out, m_stage[2]);
        chk({req, " pad_oe"}, pad_oe, e[2]);
        chk({req, " pad_do"}, pad_do, e[1]);
        chk({req, " pad_pue"}, pad_pue, e[0]);
    endtask

    // one clock: model follows R2..R5 using inputs held across the edge
    task automatic step();
        logic [2:0] ns;
        @(posedge clk);
        ns = m_stage;
        if (rst) begin
            ns = '0;
            m_latch = '0;
        end else begin
            if (update_en) m_latch = m_stage;
            if (capture_en) ns = {pad_in, port_oe, port_pue};
            else if (shift_en) ns = {m_stage[1], m_stage[0], scan_in};
        end
        m_stage = ns;
        @(negedge clk);
    endtask

    task automatic drive(input logic si, input logic c, input logic s, input logic u);
        scan_in = si; capture_en = c; shift_en = s; update_en = u;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        // R1 reset state, seen through extest
        extest = 1'b1;
        port_oe = 1; port_do = 1; port_pue = 1;
        check_all("R1 reset");

        // R3 shift a 1,0,1 pattern, R8 scan_out order
        extest = 0;
        drive(1, 0, 1, 0); step(); check_all("R3 shift1");
        drive(0, 0, 1, 0); step(); check_all("R3 shift2");
        drive(1, 0, 1, 0); step(); check_all("R3 shift3");
        chk("R3 first bit reaches scan_out", scan_out, 1'b1);
        drive(0, 0, 0, 0); step(); check_all("R8 hold");

        // R6 port drives pad while latches differ
        drive(0, 0, 0, 1); step();
        port_oe = 0; port_do = 1; port_pue = 0; #1;
        check_all("R6 sample mode");
        // R7 preloaded pattern on pad
        extest = 1; #1;
        drive(0, 0, 0, 0);
        check_all("R7 extest");
        chk("R7 pad_oe from control latch", pad_oe, 1'b0);
        chk("R7 pad_pue from pull-up latch", pad_pue, 1'b1);

        // R4 capture beats shift; R2 raw pad level captured
        pad_in = 1; port_oe = 1; port_pue = 0;
        drive(0, 1, 1, 0); step(); check_all("R4 capture priority");
        chk("R2 data stage has pad_in", scan_out, 1'b1);
        // R5 latches hold without update
        pad_in = 0;
        drive(0, 1, 0, 0); step(); check_all("R5 latch hold");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            scan_in  = r[0];
            capture_en = ($urandom % 6) == 0;
            shift_en = ($urandom % 3) != 0;
            update_en = ($urandom % 5) == 0;
            extest   = r[1] & r[2];
            port_oe  = r[3]; port_do = r[4]; port_pue = r[5]; pad_in = r[6];
            if (i == 300) rst = 1'b1;
            step();
            rst = 1'b0;
            check_all("R2/R3/R5/R6/R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule